// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns one pointer movement sample into a five-byte report and stores the bytes in a byte queue. A receive channel drains that queue one byte at a time. A sample is made of a signed horizontal delta, a signed vertical delta and three button flags, and it is offered with a single-cycle valid strobe.

The first byte of the report is a header. It starts from 0x87, and each pressed button clears one of its low three bits. The second byte is the horizontal delta clipped to ±127. The third byte is the vertical delta with its sign flipped, then clipped the same way. The last two bytes are always zero.

The encoder writes one byte per clock cycle and holds `busy` while it does so. The reader sees the head of the queue on `rd_data` and pops it with `rd_pop`. The `rx_avail` output stays high for as long as any byte is waiting.

Top module: `mouse_pkt_enc`

## Requirements
- R1: The first byte of each report is 0x87, with bit 2 cleared when `smp_btn[2]` (left) is 1, bit 1 cleared when `smp_btn[1]` (middle) is 1 and bit 0 cleared when `smp_btn[0]` (right) is 1.
- R2: The second byte is `smp_dx` as a two's-complement byte: values above +127 give 0x7F, values below −127 give 0x81, and every other value is passed unchanged.
- R3: The third byte is the negation of `smp_dy`, clipped to −127..+127 in two's complement. The negation is exact for the most negative input, which gives 0x7F.
- R4: The fourth and fifth bytes are 0x00. The queue receives the bytes in the order header, X, Y, zero, zero.
- R5: The queue holds up to DEPTH (256) bytes and returns them in first-in, first-out order.
- R6: A sample is accepted only if the queue has at least five free entries in the cycle that `smp_valid` is high. Otherwise none of its bytes are written and `busy` stays low.
- R7: `busy` rises in the cycle after a sample is accepted and stays high for exactly five cycles, one byte being queued in each of those cycles. A sample presented while `busy` is high is ignored.
- R8: `rx_avail` is high exactly while the queue is not empty, and `rd_data` shows the oldest byte. `rd_pop` removes that byte. On an empty queue `rd_data` reads 0x00 and a pop does nothing.
- R9: After reset the queue is empty, `busy` and `rx_avail` are low, and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_dx | input | IN_W | Signed horizontal delta |
| smp_dy | input | IN_W | Signed vertical delta |
| smp_btn | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| busy | output | 1 | Report being written into the queue |
| rd_pop | input | 1 | Remove the head byte |
| rd_data | output | 8 | Head byte, 0x00 when empty |
| rx_avail | output | 1 | Queue holds at least one byte |

## Verification
Random deltas spread around the clip points exercise the pass-through and saturated paths of both axes against bench-side clip functions. Directed values at ±127, ±128 and the extreme negative code separate an off-by-one clip limit and a wrapping negation from correct behaviour. All eight button combinations are covered, so a swapped or non-inverted header bit shows up. Filling the queue with 51 reports and then offering one more tests the five-free-entry rule. A strobe held high during a report checks that input is ignored while `busy` is high.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int PKT_LEN = 5;

  function automatic logic [7:0] mpe_clip(input logic signed [31:0] v);
    if (v > 32'sd127)       return 8'h7F;
    else if (v < -32'sd127) return 8'h81;
    else                    return v[7:0];
  endfunction

  function automatic logic [7:0] mpe_header(input logic [2:0] btn);
    return 8'h87 & ~{5'b0, btn};
  endfunction
endpackage

// File: rtl/mpe_encoder.sv
module mpe_encoder
  import mpe_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_valid,
  input  logic signed [IN_W-1:0] smp_dx,
  input  logic signed [IN_W-1:0] smp_dy,
  input  logic [2:0]             smp_btn,
  input  logic                   room_ok,
  output logic                   busy,
  output logic                   accept,
  output logic                   push,
  output logic [7:0]             push_byte
);
  localparam int IW = $clog2(PKT_LEN);

  logic [7:0]          pkt_q [PKT_LEN];
  logic [IW-1:0]       idx;
  logic signed [31:0]  dx_w, dy_w;

  assign dx_w   = smp_dx;
  assign dy_w   = smp_dy;
  assign accept = smp_valid && !busy && room_ok;
  assign push      = busy;
  assign push_byte = pkt_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      for (int i = 0; i < PKT_LEN; i++) pkt_q[i] <= 8'h00;
    end else if (accept) begin
      busy     <= 1'b1;
      idx      <= '0;
      pkt_q[0] <= mpe_header(smp_btn);
      pkt_q[1] <= mpe_clip(dx_w);
      pkt_q[2] <= mpe_clip(-dy_w);
      for (int i = 3; i < PKT_LEN; i++) pkt_q[i] <= 8'h00;
    end else if (busy) begin
      if (idx == IW'(PKT_LEN - 1)) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mpe_fifo.sv
module mpe_fifo #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_byte,
  input  logic          pop,
  output logic [7:0]    head,
  output logic          not_empty,
  output logic [CW-1:0] count,
  output logic          do_push,
  output logic          do_pop
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  assign do_push   = push && (count != CW'(DEPTH));
  assign do_pop    = pop && (count != '0);
  assign not_empty = (count != '0);
  assign head      = not_empty ? mem[rptr] : 8'h00;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int DEPTH = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_valid,
  input  logic signed [IN_W-1:0] smp_dx,
  input  logic signed [IN_W-1:0] smp_dy,
  input  logic [2:0]             smp_btn,
  output logic                   busy,
  input  logic                   rd_pop,
  output logic [7:0]             rd_data,
  output logic                   rx_avail
);
  localparam int CW = $clog2(DEPTH + 1);

  // named internal events for the checker
  logic          ev_accept, ev_push, ev_do_push, ev_do_pop, room_ok;
  logic [7:0]    ev_push_byte;
  logic [CW-1:0] q_count;

  assign room_ok = (q_count <= CW'(DEPTH - PKT_LEN));

  mpe_encoder #(.IN_W(IN_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_dx(smp_dx), .smp_dy(smp_dy), .smp_btn(smp_btn),
    .room_ok(room_ok), .busy(busy), .accept(ev_accept),
    .push(ev_push), .push_byte(ev_push_byte)
  );

  mpe_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(ev_push), .push_byte(ev_push_byte),
    .pop(rd_pop), .head(rd_data), .not_empty(rx_avail), .count(q_count),
    .do_push(ev_do_push), .do_pop(ev_do_pop)
  );
endmodule

// File: rtl/mpe_checker.sv
module mpe_checker #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          busy,
  input logic          push,
  input logic          do_push,
  input logic          do_pop,
  input logic          rx_avail,
  input logic [7:0]    rd_data,
  input logic [CW-1:0] q_count
);
  logic [2:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  // R5: count never passes capacity
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));
  // R5: count steps by one on a lone push
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !do_pop) |=> (q_count == $past(q_count) + 1'b1));
  // R6: acceptance only with five free entries
  a_r6_room: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (q_count <= CW'(DEPTH - 5)));
  // R6: a queued byte is never lost
  a_r6_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> do_push);
  // R7: busy rises only after an acceptance
  a_r7_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept));
  // R7: busy lasts exactly five cycles
  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == 3'd5));
  // R8: empty queue reads zero
  a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_avail |-> (rd_data == 8'h00));
endmodule

bind mouse_pkt_enc mpe_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(ev_accept), .busy(busy),
  .push(ev_push), .do_push(ev_do_push), .do_pop(ev_do_pop),
  .rx_avail(rx_avail), .rd_data(rd_data), .q_count(q_count)
);

// File: tb/test_mouse_pkt_enc.sv
module test_mouse_pkt_enc;
  localparam int IN_W  = 16;
  localparam int DEPTH = 256;

  logic clk = 0, rst_n = 0, smp_valid = 0, rd_pop = 0;
  logic signed [IN_W-1:0] smp_dx = '0, smp_dy = '0;
  logic [2:0] smp_btn = '0;
  logic busy, rx_avail;
  logic [7:0] rd_data;

  int total = 0, bad = 0;
  logic [7:0] mq[$];

  always #2.5 clk = ~clk;

  mouse_pkt_enc #(.IN_W(IN_W), .DEPTH(DEPTH)) i_mouse_pkt_enc (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_dx(smp_dx),
    .smp_dy(smp_dy), .smp_btn(smp_btn), .busy(busy), .rd_pop(rd_pop),
    .rd_data(rd_data), .rx_avail(rx_avail)
  );

  function automatic logic [7:0] b_hdr(input logic [2:0] b);
    logic [7:0] h = 8'h80;
    if (!b[2]) h[2] = 1'b1;
    if (!b[1]) h[1] = 1'b1;
    if (!b[0]) h[0] = 1'b1;
    return h;
  endfunction

  function automatic logic [7:0] b_sat(input int v);
    int c = (v > 127) ? 127 : ((v < -127) ? -127 : v);
    return 8'(c);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_sample(input int dx, input int dy, input logic [2:0] b);
    if (mq.size() <= DEPTH - 5) begin
      mq.push_back(b_hdr(b));
      mq.push_back(b_sat(dx));
      mq.push_back(b_sat(-dy));
      mq.push_back(8'h00);
      mq.push_back(8'h00);
    end
  endtask

  // drive one sample, check busy length (R7, R6)
  task automatic send(input int dx, input int dy, input logic [2:0] b);
    int n = 0;
    bit fits = (mq.size() <= DEPTH - 5);
    @(negedge clk);
    smp_dx = IN_W'(dx); smp_dy = IN_W'(dy); smp_btn = b; smp_valid = 1;
    model_sample(dx, dy, b);
    @(negedge clk);
    smp_valid = 0;
    while (busy && n < 20) begin n++; @(negedge clk); end
    chk(fits ? "R7 busy length" : "R6 dropped sample busy", n, fits ? 5 : 0);
  endtask

  task automatic pop_check(input string req);
    logic [7:0] e = (mq.size() != 0) ? mq.pop_front() : 8'h00;
    @(negedge clk);
    chk(req, rd_data, e);
    rd_pop = 1;
    @(negedge clk);
    rd_pop = 0;
  endtask

  task automatic drain(input string req);
    while (mq.size() != 0) pop_check(req);
    chk("R8 rx_avail low when drained", rx_avail, 0);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy reset", busy, 0);
    chk("R9 rx_avail reset", rx_avail, 0);
    chk("R9 rd_data reset", rd_data, 0);
    rst_n = 1;
    @(negedge clk);

    // R7: one byte per cycle; rx_avail rises one cycle after busy
    smp_dx = 16'sd5; smp_dy = 16'sd3; smp_btn = 3'b000; smp_valid = 1;
    model_sample(5, 3, 3'b000);
    @(negedge clk);
    smp_valid = 0;
    chk("R7 busy after accept", busy, 1);
    chk("R7 first byte not yet queued", rx_avail, 0);
    @(negedge clk);
    chk("R7 first byte queued", rx_avail, 1);
    repeat (5) @(negedge clk);
    drain("R4 packet order");

    // R1 all button combinations
    for (int b = 0; b < 8; b++) begin
      send(0, 0, 3'(b));
      drain("R1 header");
    end

    // R2 R3 directed clip corners
    send(127, 127, 3'b101);   drain("R2 R3 at limit");
    send(128, -128, 3'b010);  drain("R2 R3 past limit");
    send(-127, -127, 3'b000); drain("R2 R3 negative limit");
    send(-128, 128, 3'b111);  drain("R2 R3 below limit");
    send(-32768, -32768, 3'b000); drain("R3 extreme negate");
    send(32767, 32767, 3'b000);   drain("R2 extreme positive");

    // random samples
    for (int i = 0; i < 40; i++) begin
      int dx = (i % 4 == 0) ? int'($signed(16'($urandom))) : int'($urandom_range(0, 600)) - 300;
      int dy = (i % 5 == 0) ? int'($signed(16'($urandom))) : int'($urandom_range(0, 600)) - 300;
      send(dx, dy, 3'($urandom));
      if (i % 3 == 2) drain("R2 R3 random");
    end
    drain("R5 random order");

    // R7: strobe held during busy is ignored
    @(negedge clk);
    smp_dx = 16'sd9; smp_dy = -16'sd9; smp_btn = 3'b100; smp_valid = 1;
    model_sample(9, -9, 3'b100);
    @(negedge clk);
    smp_dx = 16'sd77; smp_btn = 3'b011;
    @(negedge clk);
    @(negedge clk);
    smp_valid = 0;
    repeat (8) @(negedge clk);
    drain("R7 sample during busy ignored");

    // R5 R6 fill: 51 reports fit, the 52nd is dropped
    for (int i = 0; i < 52; i++) send(i * 7 - 150, 150 - i * 5, 3'(i));
    chk("R5 fill size", mq.size(), 255);
    drain("R5 R6 full queue contents");

    // R8 pop on empty reads zero and has no effect
    pop_check("R8 pop empty");
    chk("R8 still empty", rx_avail, 0);
    send(1, 1, 3'b000);
    drain("R8 after empty pop");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule